// File: doc/BRIEF.md
# Cascaded SRAM Write Command Decoder

This block sits in each device of a cascade of up to 31 search-engine devices that share one host command bus. It watches that bus for a four-cycle SRAM write command. The command has two half-cycles, A and B, on the double-rate clock, followed by two cycles that carry no information. The device owns the write only when three conditions hold: the space-select field on the data bus names SRAM, the device-select field equals the device's strapped ID, and the burst bit is clear.

The owning device builds a 22-bit SRAM address. The top two bits come from the command bus in half-cycle A, and the low twenty bits come from the data bus in half-cycle B. The address travels down a latency pipeline, so the write reaches the external SRAM bus a fixed `LAT` cycles after half-cycle B. This matches the search-result latency. Because of the pipeline, commands issued back to back every four cycles can all be in flight at once.

All timing below counts cycles of `clk_i`, which is the double-rate clock. A command therefore occupies cycles A, B, D1 and D2.

Top module: `sram_wr_decoder`

## Requirements
- R1: While `rst_ni` is low, `sram_we_no`, `sram_ale_no` and `sram_oe_no` are high, `sram_addr_oe_o` is low and `sram_addr_o` is zero.
- R2: A write starts only if the write opcode `cmd_i[1:0] == 2'b01` is present with `cmd_vld_i` high in both half-cycle A and half-cycle B. Any other opcode, or a missing valid, issues no write.
- R3: A write is issued only when `dq_i[20:19] == 2'b10` in half-cycle A. The values 00, 01 and 11 issue no write.
- R4: A write is issued only when `dq_i[25:21]` equals `dev_id_i` in half-cycle A.
- R5: A command with `cmd_i[2] == 1` issues no write.
- R6: The write address is `{cmd_i[8:7]` sampled in half-cycle A, `dq_i[19:0]` sampled in half-cycle B`}`. The value of `cmd_i[8:7]` in half-cycle B has no effect.
- R7: Bus contents in cycles D1 and D2 are ignored, even when they look like a valid write command.
- R8: A new command may begin in the cycle right after D2.
- R9: If half-cycle B is cycle n, then in cycle n+LAT, and only in that cycle, `sram_we_no` and `sram_ale_no` are low and `sram_addr_o` carries the address with `sram_addr_oe_o` high.
- R10: `sram_oe_no` is always high. Outside a write cycle, `sram_addr_oe_o` is low and `sram_addr_o` is zero.
- R11: Commands issued every four cycles each produce their own write, none lost or merged, including when `LAT` spans more than one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate command clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_id_i | input | 5 | Strapped device ID |
| cmd_vld_i | input | 1 | Command valid |
| cmd_i | input | 9 | Command bus: opcode [1:0], burst [2], high address [8:7] |
| dq_i | input | 68 | Data bus: low address [19:0], space select [20:19], device select [25:21] |
| sram_addr_o | output | 22 | SRAM address, zero when not driven |
| sram_addr_oe_o | output | 1 | Address output enable (models the tri-state) |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_ale_no | output | 1 | Address latch enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, held high |

## Verification
With `LAT` = 4 and commands every four cycles, one earlier write leaves on the SRAM bus in the same cycle that the next command's half-cycle B is decoded and pushed into the pipeline. The bench provokes this by issuing every command immediately after the previous one ends. It covers all 31 device IDs, mismatching IDs, the three non-SRAM selects, burst commands, broken opcodes and decoy commands placed in the dead cycles. A per-cycle expectation table, filled from the B-cycle index plus `LAT`, is compared with the SRAM bus in every cycle. This catches lost, shifted, spurious or wrongly addressed pulses.

// File: rtl/sramw_pkg.sv
package sramw_pkg;
  typedef enum logic [1:0] {PH_A, PH_B, PH_D1, PH_D2} ph_e;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] SEL_SRAM = 2'b10;
endpackage

// File: rtl/sramw_cmd_fsm.sv
module sramw_cmd_fsm #(
  parameter int ID_W   = 5,
  parameter int ADDR_W = 22,
  parameter int DQ_W   = 68,
  parameter int CMD_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              cmd_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o
);
  import sramw_pkg::*;

  localparam int LO_W    = ADDR_W - 2;
  localparam int SEL_LSB = LO_W - 1;
  localparam int ID_LSB  = SEL_LSB + 2;
  localparam int HI_LSB  = CMD_W - 2;

  ph_e        ph_q, ph_d;
  logic       hit_q;
  logic [1:0] hi_q;
  logic       is_wr, a_ok;

  assign is_wr = cmd_vld_i && (cmd_i[1:0] == OP_WRITE);
  assign a_ok  = is_wr && !cmd_i[2]
              && (dq_i[SEL_LSB +: 2] == SEL_SRAM)
              && (dq_i[ID_LSB +: ID_W] == dev_id_i);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_A:    if (is_wr) ph_d = PH_B;
      PH_B:    ph_d = PH_D1;
      PH_D1:   ph_d = PH_D2;
      default: ph_d = PH_A;
    endcase
  end

  // every device tracks the phases so dead cycles are never decoded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_A;
      hit_q <= 1'b0;
      hi_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_A) begin
        hit_q <= a_ok;
        hi_q  <= cmd_i[HI_LSB +: 2];
      end
    end
  end

  assign push_o      = (ph_q == PH_B) && hit_q && is_wr && !cmd_i[2];
  assign push_addr_o = {hi_q, dq_i[LO_W-1:0]};

  logic unused_bits;
  assign unused_bits = ^{dq_i[DQ_W-1:ID_LSB+ID_W], cmd_i[HI_LSB-1:3]};
endmodule

// File: rtl/sramw_lat_pipe.sv
module sramw_lat_pipe #(
  parameter int ADDR_W = 22,
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic              out_vld_o,
  output logic [ADDR_W-1:0] out_addr_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign out_vld_o  = in_vld_i;
      assign out_addr_o = in_addr_i;
    end else begin : g_shift
      logic [STAGES-1:0] vld_q;
      logic [ADDR_W-1:0] addr_q [STAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q     <= '0;
          addr_q[0] <= '0;
        end else begin
          vld_q[0]  <= in_vld_i;
          addr_q[0] <= in_addr_i;
        end
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            vld_q[i]  <= 1'b0;
            addr_q[i] <= '0;
          end else begin
            vld_q[i]  <= vld_q[i-1];
            addr_q[i] <= addr_q[i-1];
          end
        end
      end

      assign out_vld_o  = vld_q[STAGES-1];
      assign out_addr_o = addr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sramw_bus_drv.sv
module sramw_bus_drv #(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_addr_oe_o,
  output logic              sram_we_no,
  output logic              sram_ale_no,
  output logic              sram_oe_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o    <= '0;
      sram_addr_oe_o <= 1'b0;
      sram_we_no     <= 1'b1;
      sram_ale_no    <= 1'b1;
    end else begin
      sram_addr_o    <= wr_vld_i ? wr_addr_i : '0;
      sram_addr_oe_o <= wr_vld_i;
      sram_we_no     <= !wr_vld_i;
      sram_ale_no    <= !wr_vld_i;
    end
  end

  assign sram_oe_no = 1'b1;
endmodule

// File: rtl/sram_wr_decoder.sv
module sram_wr_decoder #(
  parameter int ID_W   = 5,
  parameter int ADDR_W = 22,
  parameter int DQ_W   = 68,
  parameter int CMD_W  = 9,
  parameter int LAT    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              cmd_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_addr_oe_o,
  output logic              sram_we_no,
  output logic              sram_ale_no,
  output logic              sram_oe_no
);
  // bus driver register supplies the last cycle of latency
  localparam int PIPE_STG = LAT - 1;

  logic              push;
  logic [ADDR_W-1:0] push_addr;
  logic              wr_vld;
  logic [ADDR_W-1:0] wr_addr;

  sramw_cmd_fsm #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W), .CMD_W(CMD_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_id_i    (dev_id_i),
    .cmd_vld_i   (cmd_vld_i),
    .cmd_i       (cmd_i),
    .dq_i        (dq_i),
    .push_o      (push),
    .push_addr_o (push_addr)
  );

  sramw_lat_pipe #(.ADDR_W(ADDR_W), .STAGES(PIPE_STG)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_vld_i   (push),
    .in_addr_i  (push_addr),
    .out_vld_o  (wr_vld),
    .out_addr_o (wr_addr)
  );

  sramw_bus_drv #(.ADDR_W(ADDR_W)) u_drv (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_vld_i       (wr_vld),
    .wr_addr_i      (wr_addr),
    .sram_addr_o    (sram_addr_o),
    .sram_addr_oe_o (sram_addr_oe_o),
    .sram_we_no     (sram_we_no),
    .sram_ale_no    (sram_ale_no),
    .sram_oe_no     (sram_oe_no)
  );
endmodule

// File: rtl/sramw_chk.sv
module sramw_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_addr_oe_o,
  input logic              sram_we_no,
  input logic              sram_ale_no,
  input logic              sram_oe_no
);
  a_r10_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_oe_no);

  a_r10_addr_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_addr_oe_o |-> (sram_we_no && sram_addr_o == '0));

  a_r9_we_drives_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_addr_oe_o);

  a_r9_ale_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ale_no == sram_we_no);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> sram_we_no);
endmodule

bind sram_wr_decoder sramw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sram_addr_o    (sram_addr_o),
  .sram_addr_oe_o (sram_addr_oe_o),
  .sram_we_no     (sram_we_no),
  .sram_ale_no    (sram_ale_no),
  .sram_oe_no     (sram_oe_no)
);

// File: tb/sim_sram_wr_decoder.sv
`timescale 1ns/1ps
module sim_sram_wr_decoder;
  localparam int LAT  = 4;
  localparam int NCYC = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dev_id = '0;
  logic        cmd_vld = 1'b0;
  logic [8:0]  cmd = '0;
  logic [67:0] dq = '0;
  logic [21:0] sram_addr;
  logic        addr_oe, we_n, ale_n, oe_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit          exp_we   [NCYC];
  logic [21:0] exp_addr [NCYC];
  string       exp_tag  [NCYC];
  string       cur_tag = "R10";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_wr_decoder #(.LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_id_i(dev_id), .cmd_vld_i(cmd_vld),
    .cmd_i(cmd), .dq_i(dq), .sram_addr_o(sram_addr), .sram_addr_oe_o(addr_oe),
    .sram_we_no(we_n), .sram_ale_no(ale_n), .sram_oe_no(oe_n)
  );

  // per-cycle comparison of the SRAM bus against the expectation table
  always @(negedge clk) begin
    if (mon_en && cyc < NCYC) begin
      checks++;
      if (exp_we[cyc]) begin
        if (we_n !== 1'b0 || ale_n !== 1'b0 || addr_oe !== 1'b1 || oe_n !== 1'b1
            || sram_addr !== exp_addr[cyc]) begin
          failures++;
          $display("FAIL %s cyc=%0d we=%b ale=%b oe_en=%b addr=%h expected we=0 ale=0 oe_en=1 addr=%h",
                   exp_tag[cyc], cyc, we_n, ale_n, addr_oe, sram_addr, exp_addr[cyc]);
        end
      end else if (we_n !== 1'b1 || ale_n !== 1'b1 || addr_oe !== 1'b0 || oe_n !== 1'b1
                   || sram_addr !== '0) begin
        failures++;
        $display("FAIL %s cyc=%0d we=%b ale=%b oe_en=%b oe=%b addr=%h expected idle bus",
                 cur_tag, cyc, we_n, ale_n, addr_oe, oe_n, sram_addr);
      end
    end
  end

  task automatic issue(input logic [4:0] id, input logic [1:0] sel, input bit burst,
                       input logic [1:0] hi, input logic [18:0] lo,
                       input logic [1:0] op_a, input logic [1:0] op_b, input bit vld_b,
                       input bit noise, input string tag);
    logic [67:0] d;
    bit expw;
    int b;
    d = {4'h5, $urandom, $urandom};
    d[25:21] = id;
    d[20:19] = sel;
    d[18:0]  = lo;
    @(negedge clk);
    cur_tag = tag;
    cmd_vld = 1'b1; cmd = {hi, 4'h0, burst, op_a}; dq = d;
    @(negedge clk);
    b = cyc;
    cmd_vld = vld_b; cmd = {~hi, 4'h0, burst, op_b};
    expw = (op_a == 2'b01) && (op_b == 2'b01) && vld_b && (sel == 2'b10)
        && (id == dev_id) && !burst;
    if (expw && b + LAT < NCYC) begin
      exp_we[b+LAT]   = 1'b1;
      exp_addr[b+LAT] = {hi, sel[0], lo};
      exp_tag[b+LAT]  = tag;
    end
    // D1/D2: decoys (R7) or junk
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cmd_vld = noise;
      cmd = {~hi, 4'h0, 1'b0, noise ? 2'b01 : 2'b11};
      dq = {4'h3, $urandom, 13'h0, dev_id, 2'b10, 19'($urandom)};
    end
  endtask

  task automatic run_tests();
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (we_n !== 1'b1 || ale_n !== 1'b1 || oe_n !== 1'b1 || addr_oe !== 1'b0 || sram_addr !== '0) begin
      failures++;
      $display("FAIL R1 we=%b ale=%b oe=%b oe_en=%b addr=%h expected 1 1 1 0 0",
               we_n, ale_n, oe_n, addr_oe, sram_addr);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R4, R6, R9, R8: every ID, matching and mismatching, issued back to back
    for (int d = 0; d < 31; d++) begin
      dev_id = 5'(d);
      issue(5'(d), 2'b10, 1'b0, 2'(d), 19'(d * 12345 + 7), 2'b01, 2'b01, 1'b1, 1'b0, "R6");
      issue(5'(d) ^ 5'h01, 2'b10, 1'b0, 2'(d), 19'(d * 777), 2'b01, 2'b01, 1'b1, 1'b0, "R4");
      issue(5'(d), 2'b10, 1'b0, ~2'(d), 19'(d * 31 + 3), 2'b01, 2'b01, 1'b1, 1'b0, "R9");
    end
    dev_id = 5'd9;
    // R3: non-SRAM selects
    issue(5'd9, 2'b00, 1'b0, 2'b11, 19'h1234, 2'b01, 2'b01, 1'b1, 1'b0, "R3");
    issue(5'd9, 2'b01, 1'b0, 2'b10, 19'h0abc, 2'b01, 2'b01, 1'b1, 1'b0, "R3");
    issue(5'd9, 2'b11, 1'b0, 2'b01, 19'h7fff, 2'b01, 2'b01, 1'b1, 1'b0, "R3");
    // R5: burst bit set
    issue(5'd9, 2'b10, 1'b1, 2'b11, 19'h2222, 2'b01, 2'b01, 1'b1, 1'b0, "R5");
    issue(5'd9, 2'b10, 1'b0, 2'b00, 19'h3333, 2'b01, 2'b01, 1'b1, 1'b0, "R5");
    // R2: wrong opcodes and missing valid in B
    issue(5'd9, 2'b10, 1'b0, 2'b01, 19'h4444, 2'b00, 2'b01, 1'b1, 1'b0, "R2");
    issue(5'd9, 2'b10, 1'b0, 2'b01, 19'h4445, 2'b10, 2'b01, 1'b1, 1'b0, "R2");
    issue(5'd9, 2'b10, 1'b0, 2'b01, 19'h4446, 2'b11, 2'b01, 1'b1, 1'b0, "R2");
    issue(5'd9, 2'b10, 1'b0, 2'b01, 19'h4447, 2'b01, 2'b10, 1'b1, 1'b0, "R2");
    issue(5'd9, 2'b10, 1'b0, 2'b01, 19'h4448, 2'b01, 2'b01, 1'b0, 1'b0, "R2");
    // R7: decoy commands in the dead cycles
    for (int k = 0; k < 4; k++)
      issue(5'd9, 2'b10, 1'b0, 2'(k), 19'(k * 4099 + 1), 2'b01, 2'b01, 1'b1, 1'b1, "R7");
    // R11, R8: dense run of accepted writes with LAT across commands
    for (int k = 0; k < 8; k++)
      issue(5'd9, 2'b10, 1'b0, 2'(k + 1), 19'(k * 65537 + 5), 2'b01, 2'b01, 1'b1, 1'b0, "R11");
    @(negedge clk);
    cmd_vld = 1'b0; cmd = '0;
    cur_tag = "R10";
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule